// File: doc/BRIEF.md
# Auxiliary Memory Block Copy Engine

This block copies data between main memory and a separate auxiliary memory, one 8-byte beat at a time. Software sets it up through 16-bit and 32-bit register writes. There is a main-memory address, an auxiliary-memory address, a transfer word that holds both the byte count and the direction, and a size limit for the auxiliary memory. Writing the transfer word in the right way starts the copy.

During a copy the engine reads the source memory and then writes the destination memory. After each beat both addresses move forward by 8 and the count drops by 8. A beat whose auxiliary address is at or above the programmed size makes no access on either side and leaves both addresses where they are, but the count still drains. A count that is not a multiple of 8 is rounded up to whole beats. A busy output is high while a copy runs. A one-cycle done pulse marks the end of each copy for the interrupt logic.

Top module: `auxBlockDma`

## Requirements
- R1: After reset the main address, auxiliary address and transfer word are zero, the size limit holds the parameter SIZE_RESET (default 0x100), and busy and donePulse are low.
- R2: Each 32-bit register is reached as two 16-bit halves. The high half is at the even offset and the low half at that offset plus 2: main address 0x20/0x22, auxiliary address 0x24/0x26, transfer word 0x28/0x2A, size limit 0x2C/0x2E. A narrow write (regWide=0) loads regWdata[15:0] into one half. A wide write (regWide=1) to a high offset loads all 32 bits. regRdata returns the half selected by regAddr.
- R3: A copy starts on a narrow write to 0x2A or a wide write to 0x28. A narrow write to 0x28 only updates the high half and starts nothing.
- R4: Bit 31 of the transfer word sets the direction: 0 copies main to auxiliary, 1 copies auxiliary to main. Each in-range beat copies one 64-bit word from the source address to the destination address, then adds 8 to both addresses. Memory word index is address divided by 8.
- R5: Bits 30:0 of the transfer word hold the byte count. Each beat lowers it by 8, saturating at zero, so a count of n makes ceil(n/8) beats. The copy ends when the count is zero, and bit 31 is kept.
- R6: A beat whose auxiliary address is greater than or equal to the size limit makes no request on either memory and leaves both addresses unchanged, but still lowers the count.
- R7: busy is high from the cycle after the starting write until the copy ends. donePulse is high for exactly one cycle, in the first cycle busy is low again.
- R8: While busy, every register write is ignored, including a further start request. The register contents after the copy are exactly those the copy itself produces.
- R9: A start with a zero byte count makes no memory access and gives a done pulse after a single busy cycle.
- R10: The size limit can be written and read back like the other registers, and it takes effect on the next copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regWide | input | 1 | 1: 32-bit write, 0: 16-bit write |
| regAddr | input | 8 | Register byte offset for writes and reads |
| regWdata | input | 32 | Register write data (low 16 bits for narrow writes) |
| regRdata | output | 16 | Half-register selected by regAddr |
| mainReq | output | 1 | Main memory request |
| mainWe | output | 1 | Main memory write enable (with mainReq) |
| mainAddr | output | 32 | Main memory byte address |
| mainWdata | output | 64 | Main memory write data |
| mainRdata | input | 64 | Main memory read data, valid the cycle after a read request |
| auxReq | output | 1 | Auxiliary memory request |
| auxWe | output | 1 | Auxiliary memory write enable (with auxReq) |
| auxAddr | output | 32 | Auxiliary memory byte address |
| auxWdata | output | 64 | Auxiliary memory write data |
| auxRdata | input | 64 | Auxiliary memory read data, valid the cycle after a read request |
| busy | output | 1 | Copy in progress |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a copy that crosses the size limit partway through. After that point the beats are silent: the addresses stop moving while the count keeps draining. The sweep gets there by placing the auxiliary start address just below, exactly at, and above a small programmed limit. It crosses those positions with both directions and with counts that are not multiples of 8. For each case the bench predicts the final addresses, the memory contents and the number of accesses. A second hard case is a write that lands in the middle of a running copy. The bench issues address, size and start writes a few cycles after a long copy begins, then checks that the final register values match the undisturbed copy.

// File: rtl/auxDmaPkg.sv
package auxDmaPkg;
  localparam int REG_W      = 32;
  localparam int HALF_W     = REG_W / 2;
  localparam int CNT_W      = REG_W - 1;
  localparam int DATA_W     = 64;
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int OFF_W      = 8;
  localparam int NUM_REGS   = 4;

  localparam int IDX_MAIN = 0;
  localparam int IDX_AUX  = 1;
  localparam int IDX_CNT  = 2;
  localparam int IDX_SIZE = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic issueRead;   // read the source memory
    logic issueWrite;  // write the destination memory
    logic stepAddr;    // advance both addresses by one beat
    logic stepCount;   // lower the count by one beat (saturating)
  } dpStrobe_t;
endpackage

// File: rtl/auxDmaPath.sv
module auxDmaPath
  import auxDmaPkg::*;
#(
  parameter logic [OFF_W-1:0] OFF_BASE   = 8'h20,
  parameter logic [REG_W-1:0] SIZE_RESET = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regWide,
  input  logic [OFF_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [HALF_W-1:0] regRdata,
  input  logic              busy,
  input  dpStrobe_t         strobe,
  output logic              startReq,
  output logic              cntZero,
  output logic              inRange,
  output logic              mainReq,
  output logic              mainWe,
  output logic [REG_W-1:0]  mainAddr,
  output logic [DATA_W-1:0] mainWdata,
  input  logic [DATA_W-1:0] mainRdata,
  output logic              auxReq,
  output logic              auxWe,
  output logic [REG_W-1:0]  auxAddr,
  output logic [DATA_W-1:0] auxWdata,
  input  logic [DATA_W-1:0] auxRdata
);
  logic [REG_W-1:0] regQ [NUM_REGS];
  logic [NUM_REGS-1:0] hiHit, loHit;
  logic wrOk;
  logic dirAux2Main;
  logic [CNT_W-1:0] cntBody, cntNext;

  // offset decode per register: high half at base+4i, low half 2 above
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [OFF_W-1:0] HI_OFF = OFF_BASE + OFF_W'(4 * i);
    localparam logic [OFF_W-1:0] LO_OFF = HI_OFF + OFF_W'(2);
    assign hiHit[i] = (regAddr == HI_OFF);
    assign loHit[i] = (regAddr == LO_OFF);
  end

  function automatic logic [REG_W-1:0] mergeWrite(
    input logic [REG_W-1:0] oldVal, input logic hi, input logic lo,
    input logic wide, input logic [REG_W-1:0] data);
    logic [REG_W-1:0] r;
    r = oldVal;
    if (hi && wide)       r = data;
    else if (hi)          r[REG_W-1:HALF_W] = data[HALF_W-1:0];
    else if (lo && !wide) r[HALF_W-1:0] = data[HALF_W-1:0];
    return r;
  endfunction

  assign wrOk     = regWe && !busy;
  assign startReq = wrOk && ((loHit[IDX_CNT] && !regWide) || (hiHit[IDX_CNT] && regWide));

  assign cntBody = regQ[IDX_CNT][CNT_W-1:0];
  assign cntNext = (cntBody < CNT_W'(BEAT_BYTES)) ? '0 : cntBody - CNT_W'(BEAT_BYTES);
  assign cntZero = (cntBody == '0);
  assign dirAux2Main = regQ[IDX_CNT][REG_W-1];
  assign inRange = (regQ[IDX_AUX] < regQ[IDX_SIZE]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++)
        regQ[i] <= (i == IDX_SIZE) ? SIZE_RESET : '0;
    end else begin
      if (wrOk) begin
        for (int i = 0; i < NUM_REGS; i++)
          regQ[i] <= mergeWrite(regQ[i], hiHit[i], loHit[i], regWide, regWdata);
      end
      if (strobe.stepAddr) begin
        regQ[IDX_MAIN] <= regQ[IDX_MAIN] + REG_W'(BEAT_BYTES);
        regQ[IDX_AUX]  <= regQ[IDX_AUX] + REG_W'(BEAT_BYTES);
      end
      if (strobe.stepCount)
        regQ[IDX_CNT] <= {dirAux2Main, cntNext};
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hiHit[i]) regRdata = regQ[i][REG_W-1:HALF_W];
      if (loHit[i]) regRdata = regQ[i][HALF_W-1:0];
    end
  end

  // memory sides: source read then destination write, data passed through
  assign mainAddr  = regQ[IDX_MAIN];
  assign auxAddr   = regQ[IDX_AUX];
  assign mainReq   = dirAux2Main ? strobe.issueWrite : strobe.issueRead;
  assign mainWe    = dirAux2Main && strobe.issueWrite;
  assign auxReq    = dirAux2Main ? strobe.issueRead : strobe.issueWrite;
  assign auxWe     = !dirAux2Main && strobe.issueWrite;
  assign mainWdata = auxRdata;
  assign auxWdata  = mainRdata;

  // R6
  aux_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (auxReq || mainReq) |-> (regQ[IDX_AUX] < regQ[IDX_SIZE]));
  // R5
  cnt_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (regQ[IDX_CNT][CNT_W-1:0] <= $past(regQ[IDX_CNT][CNT_W-1:0]))
             && (regQ[IDX_CNT][REG_W-1] == $past(regQ[IDX_CNT][REG_W-1])));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(regQ[IDX_SIZE]));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepAddr |=> regQ[IDX_MAIN] == $past(regQ[IDX_MAIN]) + REG_W'(BEAT_BYTES));
endmodule

// File: rtl/auxDmaCtrl.sv
module auxDmaCtrl
  import auxDmaPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      cntZero,
  input  logic      inRange,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      donePulse
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_t;
  state_t stateQ, stateNext;
  logic doneQ, finish;

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    finish    = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (startReq) stateNext = ST_READ;
      ST_READ: begin
        if (cntZero) begin
          finish    = 1'b1;
          stateNext = ST_IDLE;
        end else if (inRange) begin
          strobe.issueRead = 1'b1;
          stateNext        = ST_WRITE;
        end else begin
          strobe.stepCount = 1'b1;   // silent beat: drain only
        end
      end
      ST_WRITE: begin
        strobe.issueWrite = 1'b1;
        strobe.stepAddr   = 1'b1;
        strobe.stepCount  = 1'b1;
        stateNext         = ST_READ;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      doneQ  <= finish;
    end
  end

  assign busy      = (stateQ != ST_IDLE);
  assign donePulse = doneQ;

  // R7
  done_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busy);
  // R7
  end_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> donePulse);
endmodule

// File: rtl/auxBlockDma.sv
module auxBlockDma
  import auxDmaPkg::*;
#(
  parameter logic [OFF_W-1:0] OFF_BASE   = 8'h20,
  parameter logic [REG_W-1:0] SIZE_RESET = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regWide,
  input  logic [OFF_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [HALF_W-1:0] regRdata,
  output logic              mainReq,
  output logic              mainWe,
  output logic [REG_W-1:0]  mainAddr,
  output logic [DATA_W-1:0] mainWdata,
  input  logic [DATA_W-1:0] mainRdata,
  output logic              auxReq,
  output logic              auxWe,
  output logic [REG_W-1:0]  auxAddr,
  output logic [DATA_W-1:0] auxWdata,
  input  logic [DATA_W-1:0] auxRdata,
  output logic              busy,
  output logic              donePulse
);
  dpStrobe_t strobe;
  logic startReq, cntZero, inRange;

  auxDmaPath #(.OFF_BASE(OFF_BASE), .SIZE_RESET(SIZE_RESET)) u_path (
    .clk, .rstN, .regWe, .regWide, .regAddr, .regWdata, .regRdata,
    .busy, .strobe, .startReq, .cntZero, .inRange,
    .mainReq, .mainWe, .mainAddr, .mainWdata, .mainRdata,
    .auxReq, .auxWe, .auxAddr, .auxWdata, .auxRdata
  );

  auxDmaCtrl u_ctrl (
    .clk, .rstN, .startReq, .cntZero, .inRange,
    .strobe, .busy, .donePulse
  );
endmodule

// File: tb/auxBlockDma_bench.sv
module auxBlockDma_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rstN, regWe, regWide;
  logic [7:0] regAddr;
  logic [31:0] regWdata;
  logic [15:0] regRdata;
  logic mainReq, mainWe, auxReq, auxWe, busy, donePulse;
  logic [31:0] mainAddr, auxAddr;
  logic [63:0] mainWdata, auxWdata, mainRdata, auxRdata;

  auxBlockDma u_auxBlockDma (
    .clk, .rstN, .regWe, .regWide, .regAddr, .regWdata, .regRdata,
    .mainReq, .mainWe, .mainAddr, .mainWdata, .mainRdata,
    .auxReq, .auxWe, .auxAddr, .auxWdata, .auxRdata,
    .busy, .donePulse
  );

  int total = 0;
  int bad = 0;

  // bench memories and monitors
  logic [63:0] mainMem [64];
  logic [63:0] auxMem  [32];
  logic fillReq = 1'b0;
  logic [15:0] fillSeed = '0;
  int accCount = 0;
  int boundViol = 0;
  logic [31:0] curSize = 32'h100;
  logic clrAcc = 1'b0;

  function automatic logic [63:0] pat(input int side, input int idx, input logic [15:0] seed);
    return {8'(side), 8'h5A, seed, 32'(idx * 32'h0101_0003)};
  endfunction

  always @(posedge clk) begin
    if (fillReq) begin
      for (int i = 0; i < 64; i++) mainMem[i] <= pat(1, i, fillSeed);
      for (int i = 0; i < 32; i++) auxMem[i]  <= pat(2, i, fillSeed);
    end else begin
      if (mainReq) begin
        if (mainWe) mainMem[mainAddr[8:3]] <= mainWdata;
        else        mainRdata <= mainMem[mainAddr[8:3]];
      end
      if (auxReq) begin
        if (auxWe) auxMem[auxAddr[7:3]] <= auxWdata;
        else       auxRdata <= auxMem[auxAddr[7:3]];
        if (auxAddr >= curSize) boundViol <= boundViol + 1;
      end
    end
    if (clrAcc) accCount <= 0;
    else accCount <= accCount + int'(mainReq) + int'(auxReq);
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] data, input bit wide);
    @(negedge clk);
    regWe = 1'b1; regWide = wide; regAddr = off; regWdata = data;
    @(negedge clk);
    regWe = 1'b0; regWide = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [15:0] v);
    regAddr = off;
    #1;
    v = regRdata;
  endtask

  task automatic rd32(input logic [7:0] hiOff, output logic [31:0] v);
    logic [15:0] h, l;
    rd(hiOff, h);
    rd(hiOff + 8'd2, l);
    v = {h, l};
  endtask

  task automatic fill(input logic [15:0] seed);
    @(negedge clk);
    fillSeed = seed; fillReq = 1'b1; clrAcc = 1'b1;
    @(negedge clk);
    fillReq = 1'b0; clrAcc = 1'b0;
  endtask

  // waits for the done pulse; checks its width and busy
  task automatic waitDone(input string tag);
    bit seen = 0;
    for (int k = 0; k < 600 && !seen; k++) begin
      @(negedge clk);
      if (donePulse) seen = 1;
    end
    chk(seen, {tag, " R7 done pulse seen"}, 64'(seen), 64'd1);
    chk(!busy, {tag, " R7 busy low with done"}, 64'(busy), 64'd0);
    @(negedge clk);
    chk(!donePulse, {tag, " R7 done one cycle"}, 64'(donePulse), 64'd0);
  endtask

  logic [63:0] expMain [64];
  logic [63:0] expAux  [32];

  task automatic runCase(input bit dir, input int cnt, input logic [31:0] mStart,
                         input logic [31:0] aStart, input logic [31:0] size,
                         input bit wideStart, input logic [15:0] seed);
    logic [31:0] m, a, v;
    int beats, inBeats;
    bit memOk;
    fill(seed);
    curSize = size;
    wr(8'h2C, size, 1'b1);
    wr(8'h20, {16'h0, mStart[31:16]}, 1'b0);
    wr(8'h22, {16'h0, mStart[15:0]}, 1'b0);
    wr(8'h24, aStart, 1'b1);
    if (wideStart) begin
      wr(8'h28, {dir, 31'(cnt)}, 1'b1);
    end else begin
      wr(8'h28, {16'h0, dir, 15'(cnt >> 16)}, 1'b0);
      chk(!busy, "R3 high half alone no start", 64'(busy), 64'd0);
      wr(8'h2A, {16'h0, 16'(cnt)}, 1'b0);
    end
    waitDone("R4/R5/R6");
    // expected model
    for (int i = 0; i < 64; i++) expMain[i] = pat(1, i, seed);
    for (int i = 0; i < 32; i++) expAux[i]  = pat(2, i, seed);
    m = mStart; a = aStart;
    beats = (cnt + 7) / 8;
    inBeats = 0;
    for (int b = 0; b < beats; b++) begin
      if (a < size) begin
        if (!dir) expAux[a[7:3]] = expMain[m[8:3]];
        else      expMain[m[8:3]] = expAux[a[7:3]];
        a += 8; m += 8; inBeats++;
      end
    end
    memOk = 1;
    for (int i = 0; i < 64; i++) if (mainMem[i] !== expMain[i]) memOk = 0;
    for (int i = 0; i < 32; i++) if (auxMem[i] !== expAux[i]) memOk = 0;
    chk(memOk, dir ? "R4 aux->main contents" : "R4 main->aux contents", 64'(cnt), 64'(aStart));
    rd32(8'h20, v);
    chk(v == m, "R6 main addr final", 64'(v), 64'(m));
    rd32(8'h24, v);
    chk(v == a, "R6 aux addr final", 64'(v), 64'(a));
    rd32(8'h28, v);
    chk(v == {dir, 31'd0}, "R5 count drained dir kept", 64'(v), 64'({dir, 31'd0}));
    chk(accCount == 2 * inBeats, cnt == 0 ? "R9 zero count accesses" : "R6 access count",
        64'(accCount), 64'(2 * inBeats));
    chk(boundViol == 0, "R6 no out-of-range access", 64'(boundViol), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] h;
    logic [31:0] v;
    int seedCtr = 1;
    int cnts [6] = '{0, 3, 8, 13, 24, 40};
    rstN = 1'b0; regWe = 1'b0; regWide = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int o = 8'h20; o <= 8'h2E; o += 2) begin
      rd(8'(o), h);
      chk(h == ((o == 8'h2E) ? 16'h0100 : 16'h0), "R1 reset register", 64'(h),
          64'((o == 8'h2E) ? 16'h0100 : 16'h0));
    end
    chk(!busy && !donePulse, "R1 reset busy/done", 64'({busy, donePulse}), 64'd0);

    // R2 half writes, wide write, readback
    wr(8'h20, 32'hFFFF_1234, 1'b0);
    wr(8'h22, 32'hEEEE_5678, 1'b0);
    rd32(8'h20, v);
    chk(v == 32'h1234_5678, "R2 narrow halves", 64'(v), 64'h1234_5678);
    wr(8'h24, 32'h9ABC_DEF0, 1'b1);
    rd32(8'h24, v);
    chk(v == 32'h9ABC_DEF0, "R2 wide write at high offset", 64'(v), 64'h9ABC_DEF0);

    // R3 narrow write to count high half alone: no start
    wr(8'h28, 32'h0000_0000, 1'b0);
    fill(16'h0);
    wr(8'h28, 32'h0000_0001, 1'b0);
    repeat (4) @(negedge clk);
    chk(!busy && accCount == 0, "R3 count high write no start", 64'(accCount), 64'd0);
    rd(8'h28, h);
    chk(h == 16'h0001, "R3 count high half loaded", 64'(h), 64'h1);
    wr(8'h28, 32'h0, 1'b0);

    // R10 size register readback
    wr(8'h2C, 32'h0000_0040, 1'b1);
    rd32(8'h2C, v);
    chk(v == 32'h40, "R10 size readback", 64'(v), 64'h40);

    // sweep: sizes, directions, counts, aux start around the limit
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int c = 0; c < 6; c++) begin
          for (int p = 0; p < 5; p++) begin
            logic [31:0] sz, as;
            sz = (s == 0) ? 32'h40 : 32'h80;
            case (p)
              0: as = 32'h0;
              1: as = sz - 32'd16;
              2: as = sz - 32'd8;
              3: as = sz;
              default: as = sz + 32'd8;
            endcase
            runCase(d[0], cnts[c], 32'h100 + 32'(8 * p), as, sz, (c % 2) == 1, 16'(seedCtr));
            seedCtr++;
          end
        end
      end
    end

    // R8 writes during a running copy are ignored
    fill(16'hBEEF);
    curSize = 32'h100;
    wr(8'h2C, 32'h100, 1'b1);
    wr(8'h20, 32'h0000_0040, 1'b1);
    wr(8'h24, 32'h0000_0010, 1'b1);
    wr(8'h28, 32'd40, 1'b1);
    chk(busy, "R7 busy after start", 64'(busy), 64'd1);
    wr(8'h22, 32'h0000_0000, 1'b0);
    wr(8'h2C, 32'h0000_0008, 1'b1);
    wr(8'h28, 32'h8000_0010, 1'b1);
    waitDone("R8");
    repeat (3) @(negedge clk);
    chk(!busy, "R8 no restart after ignored start", 64'(busy), 64'd0);
    rd32(8'h20, v);
    chk(v == 32'h68, "R8 main addr unaffected", 64'(v), 64'h68);
    rd32(8'h24, v);
    chk(v == 32'h38, "R8 aux addr unaffected", 64'(v), 64'h38);
    rd32(8'h2C, v);
    chk(v == 32'h100, "R8 size unaffected", 64'(v), 64'h100);
    rd32(8'h28, v);
    chk(v == 32'h0, "R8 count unaffected", 64'(v), 64'h0);
    chk(accCount == 10, "R8 beat count", 64'(accCount), 64'd10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule